// File: doc/BRIEF.md
# Two-Table Display Command Decoder

This block sits behind an 8-bit parallel host bus of a dot-matrix display controller. It turns each bus transfer into one of four actions. Command writes update the display-control registers. Status reads return a status byte. Data writes and data reads produce one-cycle strobes for a display RAM that lives outside the block. A transfer is classified by a register-select line and two active-low strobes. It takes effect once, when the active strobe returns high.

Commands are decoded through one of two tables. The main table covers display enable, inverse video, all-pixels-on, the first displayed RAM line, and the page and column address. A command in the main table switches the decoder into a sub-table mode, and another command switches it back. In sub-table mode the same byte values mean something else. They set the two partial-display windows, a count of lines for alternating inverse drive and a contrast (electronic volume) level. The line count and the contrast level are first loaded nibble by nibble into staging registers. Their active outputs change only when the matching execute command arrives.

Top module: `lcd_cmd_decoder`

## Requirements
- R1: A transfer's kind comes from rs and the strobe that was low. rs=0 with wr_n low is a command write. rs=0 with rd_n low is a status read. rs=1 with wr_n low is a data write, which gives one ram_wr_stb pulse carrying the byte on ram_wdata. rs=1 with rd_n low is a data read, which gives one ram_rd_stb pulse.
- R2: A transfer is acted on exactly once, after the rising edge of its strobe. A transfer during which both strobes were low at the same time is discarded.
- R3: In main mode, 0xAE/0xAF clear/set disp_on (bit 0), 0xA6/0xA7 clear/set disp_inverse (bit 0), and 0xA4/0xA5 clear/set all_on (bit 0).
- R4: In main mode, 0x5h loads start_line[7:4]=h and 0x6l loads start_line[3:0]=l.
- R5: In main mode, 0xBp loads page_addr=p, 0x1h loads col_addr[7:4]=h and 0x0l loads col_addr[3:0]=l.
- R6: While a status read is active, dout shows {busy, disp_on, resetting, sub_mode} in bits 7..4 and zero in bits 3..0. dout is zero at all other times. resetting is 1 in the first cycle after reset is released.
- R7: 0x70 in main mode sets sub_mode. 0x71 in sub mode clears it.
- R8: In sub mode, 0x0n, 0x1n, 0x2n and 0x3n load win_a_first, win_a_len, win_b_first and win_b_len with n. 0x40 sets partial_en.
- R9: In sub mode, 0x5x stages bits 5..4 of the line count from D1..D0 and ignores D3..D2. 0x6l stages bits 3..0. Only 0x70 copies the staged count to line_inv_count and sets line_inv_active, and sub_mode stays set.
- R10: In sub mode, 0x8h and 0x9l stage the upper and lower nibble of the contrast level. vol_level changes only on 0xA0, which copies the staged byte.
- R11: A byte that is undefined in the current mode changes no state. The same byte in the other mode does not touch the other table's registers.
- R12: Synchronous reset (rst=1) leaves main mode, display off, normal video, all_on=0, every address, window, count, stage and contrast register at zero, and partial_en=0.
- R13: busy (status bit 7) is 1 for BUSY_CYCLES cycles after each command write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rs | input | 1 | Register select: 0 command/status, 1 display data |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| din | input | 8 | Write data from host |
| dout | output | 8 | Status byte during status reads |
| ram_wr_stb | output | 1 | One-cycle display RAM write pulse |
| ram_wdata | output | 8 | Byte for the RAM write |
| ram_rd_stb | output | 1 | One-cycle display RAM read pulse |
| disp_on | output | 1 | Display enabled |
| disp_inverse | output | 1 | Inverse video |
| all_on | output | 1 | All pixels forced on |
| start_line | output | 8 | RAM line shown on the first common row |
| page_addr | output | 4 | Page address |
| col_addr | output | 8 | Column address |
| sub_mode | output | 1 | Sub-table mode active |
| win_a_first | output | 4 | First partial window start unit |
| win_a_len | output | 4 | First partial window unit count |
| win_b_first | output | 4 | Second partial window start unit |
| win_b_len | output | 4 | Second partial window unit count |
| partial_en | output | 1 | Partial display enabled |
| line_inv_count | output | 6 | Active line count for inverse drive |
| line_inv_active | output | 1 | Inverse line drive executed |
| vol_level | output | 8 | Active contrast level |

## Verification
The bench builds the block with BUSY_CYCLES=3. With a window of several cycles, a status read started right after a command write can be sampled once inside the busy window and once after it. This checks both edges of R13 without a long wait. Each other value keeps its default, so every mode and staging path runs at its real width.

// File: rtl/lcd_dec_pkg.sv
package lcd_dec_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int LINE_W = 6;

  typedef enum logic [1:0] {
    XF_CMD   = 2'd0,
    XF_STAT  = 2'd1,
    XF_WDATA = 2'd2,
    XF_RDATA = 2'd3
  } xfer_e;

  typedef struct packed {
    logic              valid;
    xfer_e             kind;
    logic [BYTE_W-1:0] data;
  } xfer_t;
endpackage

// File: rtl/bus_sampler.sv
module bus_sampler
  import lcd_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rs,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [BYTE_W-1:0] din,
  output xfer_t             ev
);
  logic              rd_q, wr_q, rs_q, clash;
  logic [BYTE_W-1:0] d_q;
  logic              rise_r, rise_w;

  assign rise_r = rd_n && !rd_q;
  assign rise_w = wr_n && !wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= 1'b1;
      wr_q  <= 1'b1;
      rs_q  <= 1'b0;
      clash <= 1'b0;
      d_q   <= '0;
      ev    <= '0;
    end else begin
      rd_q <= rd_n;
      wr_q <= wr_n;
      if (!rd_n || !wr_n) rs_q <= rs;
      if (!wr_n) d_q <= din;
      if (!rd_n && !wr_n) clash <= 1'b1;
      else if (rd_n && wr_n && rd_q && wr_q) clash <= 1'b0;
      ev.valid <= 1'b0;
      if ((rise_r || rise_w) && !clash) begin
        ev.valid <= 1'b1;
        ev.data  <= d_q;
        if (rise_w) ev.kind <= rs_q ? XF_WDATA : XF_CMD;
        else        ev.kind <= rs_q ? XF_RDATA : XF_STAT;
      end
    end
  end

  // R2: one transfer yields one event, never back to back
  a_r2_single_event: assert property (@(posedge clk) disable iff (rst)
    ev.valid |=> !ev.valid);
endmodule

// File: rtl/main_table.sv
module main_table
  import lcd_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [BYTE_W-1:0] cmd,
  output logic              disp_on,
  output logic              disp_inverse,
  output logic              all_on,
  output logic [BYTE_W-1:0] start_line,
  output logic [NIB_W-1:0]  page_addr,
  output logic [BYTE_W-1:0] col_addr
);
  logic [NIB_W-1:0] op, arg;
  assign op  = cmd[BYTE_W-1:NIB_W];
  assign arg = cmd[NIB_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_on      <= 1'b0;
      disp_inverse <= 1'b0;
      all_on       <= 1'b0;
      start_line   <= '0;
      page_addr    <= '0;
      col_addr     <= '0;
    end else if (cmd_valid) begin
      case (op)
        4'h0: col_addr[NIB_W-1:0]        <= arg;
        4'h1: col_addr[BYTE_W-1:NIB_W]   <= arg;
        4'h5: start_line[BYTE_W-1:NIB_W] <= arg;
        4'h6: start_line[NIB_W-1:0]      <= arg;
        4'hB: page_addr                  <= arg;
        4'hA: begin
          case (arg[3:1])
            3'b111: disp_on      <= arg[0];
            3'b011: disp_inverse <= arg[0];
            3'b010: all_on       <= arg[0];
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  // R3: display-on command takes effect next cycle
  a_r3_on_cmd: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd == 8'hAF) |=> disp_on);
  // R11: main registers hold without a main-table command
  a_r11_main_hold: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> $stable({disp_on, disp_inverse, all_on, start_line, page_addr, col_addr}));
endmodule

// File: rtl/sub_table.sv
module sub_table
  import lcd_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [BYTE_W-1:0] cmd,
  output logic              sub_mode,
  output logic [NIB_W-1:0]  win_a_first,
  output logic [NIB_W-1:0]  win_a_len,
  output logic [NIB_W-1:0]  win_b_first,
  output logic [NIB_W-1:0]  win_b_len,
  output logic              partial_en,
  output logic [LINE_W-1:0] line_inv_count,
  output logic              line_inv_active,
  output logic [BYTE_W-1:0] vol_level
);
  logic [NIB_W-1:0]  op, arg;
  logic [LINE_W-1:0] line_stage;
  logic [BYTE_W-1:0] vol_stage;

  assign op  = cmd[BYTE_W-1:NIB_W];
  assign arg = cmd[NIB_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_mode        <= 1'b0;
      win_a_first     <= '0;
      win_a_len       <= '0;
      win_b_first     <= '0;
      win_b_len       <= '0;
      partial_en      <= 1'b0;
      line_stage      <= '0;
      line_inv_count  <= '0;
      line_inv_active <= 1'b0;
      vol_stage       <= '0;
      vol_level       <= '0;
    end else if (cmd_valid) begin
      if (!sub_mode) begin
        if (cmd == 8'h70) sub_mode <= 1'b1;
      end else begin
        case (op)
          4'h0: win_a_first <= arg;
          4'h1: win_a_len   <= arg;
          4'h2: win_b_first <= arg;
          4'h3: win_b_len   <= arg;
          4'h4: if (arg == 4'h0) partial_en <= 1'b1;
          4'h5: line_stage[LINE_W-1:NIB_W] <= arg[LINE_W-NIB_W-1:0];
          4'h6: line_stage[NIB_W-1:0]      <= arg;
          4'h7: begin
            if (arg == 4'h0) begin
              line_inv_count  <= line_stage;
              line_inv_active <= 1'b1;
            end else if (arg == 4'h1) begin
              sub_mode <= 1'b0;
            end
          end
          4'h8: vol_stage[BYTE_W-1:NIB_W] <= arg;
          4'h9: vol_stage[NIB_W-1:0]      <= arg;
          4'hA: if (arg == 4'h0) vol_level <= vol_stage;
          default: ;
        endcase
      end
    end
  end

  // R7: entering the sub table from main mode
  a_r7_enter: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !sub_mode && cmd == 8'h70) |=> sub_mode);
  // R9: execute in sub mode keeps the mode
  a_r9_exec_keeps_mode: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && sub_mode && cmd == 8'h70) |=> (sub_mode && line_inv_active));
  // R10: contrast output moves only on its commit byte
  a_r10_vol_commit_only: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && sub_mode && cmd == 8'hA0) |=> $stable(vol_level));
endmodule

// File: rtl/status_gen.sv
module status_gen
  import lcd_dec_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_done,
  input  logic              rs,
  input  logic              rd_n,
  input  logic              disp_on,
  input  logic              sub_mode,
  output logic [BYTE_W-1:0] dout
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] busy_cnt;
  logic          resetting;
  logic          busy;

  assign busy = (busy_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt  <= '0;
      resetting <= 1'b1;
      dout      <= '0;
    end else begin
      resetting <= 1'b0;
      if (cmd_done)  busy_cnt <= CW'(BUSY_CYCLES);
      else if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (!rd_n && !rs) dout <= {busy, disp_on, resetting, sub_mode, {NIB_W{1'b0}}};
      else              dout <= '0;
    end
  end

  // R6: low nibble of the status byte is always zero
  a_r6_low_zero: assert property (@(posedge clk) disable iff (rst)
    dout[NIB_W-1:0] == '0);
  // R13: a command always opens a busy window
  a_r13_busy_after_cmd: assert property (@(posedge clk) disable iff (rst)
    cmd_done |=> busy);
endmodule

// File: rtl/lcd_cmd_decoder.sv
module lcd_cmd_decoder
  import lcd_dec_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rs,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              ram_wr_stb,
  output logic [7:0]        ram_wdata,
  output logic              ram_rd_stb,
  output logic              disp_on,
  output logic              disp_inverse,
  output logic              all_on,
  output logic [7:0]        start_line,
  output logic [3:0]        page_addr,
  output logic [7:0]        col_addr,
  output logic              sub_mode,
  output logic [3:0]        win_a_first,
  output logic [3:0]        win_a_len,
  output logic [3:0]        win_b_first,
  output logic [3:0]        win_b_len,
  output logic              partial_en,
  output logic [5:0]        line_inv_count,
  output logic              line_inv_active,
  output logic [7:0]        vol_level
);
  xfer_t ev;
  logic  cmd_any, cmd_main;

  bus_sampler u_sampler (
    .clk(clk), .rst(rst), .rs(rs), .rd_n(rd_n), .wr_n(wr_n), .din(din), .ev(ev)
  );

  assign cmd_any    = ev.valid && (ev.kind == XF_CMD);
  assign cmd_main   = cmd_any && !sub_mode;
  assign ram_wr_stb = ev.valid && (ev.kind == XF_WDATA);
  assign ram_rd_stb = ev.valid && (ev.kind == XF_RDATA);
  assign ram_wdata  = ev.data;

  main_table u_main (
    .clk(clk), .rst(rst), .cmd_valid(cmd_main), .cmd(ev.data),
    .disp_on(disp_on), .disp_inverse(disp_inverse), .all_on(all_on),
    .start_line(start_line), .page_addr(page_addr), .col_addr(col_addr)
  );

  sub_table u_sub (
    .clk(clk), .rst(rst), .cmd_valid(cmd_any), .cmd(ev.data),
    .sub_mode(sub_mode), .win_a_first(win_a_first), .win_a_len(win_a_len),
    .win_b_first(win_b_first), .win_b_len(win_b_len), .partial_en(partial_en),
    .line_inv_count(line_inv_count), .line_inv_active(line_inv_active),
    .vol_level(vol_level)
  );

  status_gen #(.BUSY_CYCLES(BUSY_CYCLES)) u_status (
    .clk(clk), .rst(rst), .cmd_done(cmd_any), .rs(rs), .rd_n(rd_n),
    .disp_on(disp_on), .sub_mode(sub_mode), .dout(dout)
  );

  // R1: the two RAM strobes never fire together
  a_r1_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_wr_stb, ram_rd_stb}));
endmodule

// File: tb/lcd_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module lcd_cmd_decoder_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rs = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] din = '0;
  logic [7:0] dout, ram_wdata, start_line, col_addr, vol_level;
  logic [3:0] page_addr, win_a_first, win_a_len, win_b_first, win_b_len;
  logic [5:0] line_inv_count;
  logic ram_wr_stb, ram_rd_stb, disp_on, disp_inverse, all_on, sub_mode;
  logic partial_en, line_inv_active;

  int checks = 0, fails = 0;
  int wr_pulses = 0, rd_pulses = 0;
  logic [7:0] last_wdata = '0;
  logic [7:0] sbyte;

  always #4 clk = ~clk;

  lcd_cmd_decoder #(.BUSY_CYCLES(3)) dut_i (
    .clk(clk), .rst(rst), .rs(rs), .rd_n(rd_n), .wr_n(wr_n), .din(din),
    .dout(dout), .ram_wr_stb(ram_wr_stb), .ram_wdata(ram_wdata),
    .ram_rd_stb(ram_rd_stb), .disp_on(disp_on), .disp_inverse(disp_inverse),
    .all_on(all_on), .start_line(start_line), .page_addr(page_addr),
    .col_addr(col_addr), .sub_mode(sub_mode), .win_a_first(win_a_first),
    .win_a_len(win_a_len), .win_b_first(win_b_first), .win_b_len(win_b_len),
    .partial_en(partial_en), .line_inv_count(line_inv_count),
    .line_inv_active(line_inv_active), .vol_level(vol_level)
  );

  always @(negedge clk) begin
    if (ram_wr_stb) begin wr_pulses++; last_wdata = ram_wdata; end
    if (ram_rd_stb) rd_pulses++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] b);
    @(negedge clk); rs = 1'b0; din = b; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic stat_read(output logic [7:0] v);
    @(negedge clk); rs = 1'b0; rd_n = 1'b0;
    repeat (2) @(negedge clk);
    v = dout;
    rd_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1; rs = 1'b0; rd_n = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R6 resetting flag after release", dout, 8'h20);
    @(negedge clk);
    chk("R6 resetting flag clears", dout, 8'h00);
    rd_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R12 reset display regs", {disp_on, disp_inverse, all_on, sub_mode, partial_en, line_inv_active}, 0);
    chk("R12 reset addresses", {start_line, page_addr, col_addr}, 0);
    chk("R12 reset windows/count/level", {win_a_first, win_a_len, win_b_first, win_b_len, line_inv_count, vol_level}, 0);
    stat_read(sbyte);
    chk("R12 R6 idle status", sbyte, 8'h00);
  endtask

  task automatic t_display_flags;
    cmd(8'hAF); chk("R3 display on", disp_on, 1);
    stat_read(sbyte); chk("R6 status shows on", sbyte, 8'h40);
    cmd(8'hA7); chk("R3 inverse set", disp_inverse, 1);
    cmd(8'hA5); chk("R3 all_on set", all_on, 1);
    cmd(8'hA6); chk("R3 inverse cleared", disp_inverse, 0);
    cmd(8'hA4); chk("R3 all_on cleared", all_on, 0);
    cmd(8'hAE); chk("R3 display off", disp_on, 0);
  endtask

  task automatic t_addresses;
    cmd(8'h5A); cmd(8'h63); chk("R4 start line", start_line, 8'hA3);
    cmd(8'hB7); chk("R5 page", page_addr, 4'h7);
    cmd(8'h1C); cmd(8'h05); chk("R5 column", col_addr, 8'hC5);
  endtask

  task automatic t_data_path;
    int w0, r0;
    w0 = wr_pulses; r0 = rd_pulses;
    @(negedge clk); rs = 1'b1; din = 8'h3C; wr_n = 1'b0;
    repeat (3) @(negedge clk); wr_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 one write strobe", wr_pulses - w0, 1);
    chk("R1 write data", last_wdata, 8'h3C);
    chk("R1 R2 no read strobe on write", rd_pulses - r0, 0);
    @(negedge clk); rs = 1'b1; rd_n = 1'b0;
    repeat (3) @(negedge clk); rd_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 one read strobe", rd_pulses - r0, 1);
    chk("R1 dout zero on data read", dout, 0);
    chk("R2 no extra write strobe", wr_pulses - w0, 1);
  endtask

  task automatic t_clash;
    int w0;
    w0 = wr_pulses;
    @(negedge clk); rs = 1'b0; din = 8'hAF; wr_n = 1'b0; rd_n = 1'b0;
    repeat (2) @(negedge clk); wr_n = 1'b1; rd_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2 clash command discarded", disp_on, 0);
    @(negedge clk); rs = 1'b1; din = 8'h11; wr_n = 1'b0; rd_n = 1'b0;
    repeat (2) @(negedge clk); wr_n = 1'b1; rd_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2 clash data write discarded", wr_pulses - w0, 0);
  endtask

  task automatic t_sub_table;
    cmd(8'h70); chk("R7 enter sub mode", sub_mode, 1);
    stat_read(sbyte); chk("R6 status shows sub mode", sbyte, 8'h10);
    cmd(8'h5F); chk("R11 start line untouched in sub mode", start_line, 8'hA3);
    cmd(8'hB2); chk("R11 undefined sub byte keeps page", page_addr, 4'h7);
    cmd(8'hAF); chk("R11 main display byte ignored in sub", disp_on, 0);
    cmd(8'h5D); cmd(8'h6A);
    chk("R9 count waits for execute", {line_inv_active, line_inv_count}, 0);
    cmd(8'h70);
    chk("R9 count executed (D3..D2 ignored)", line_inv_count, 6'h1A);
    chk("R9 active and still sub mode", {line_inv_active, sub_mode}, 2'b11);
    cmd(8'h8C); cmd(8'h93);
    chk("R10 level waits for commit", vol_level, 0);
    cmd(8'hA0); chk("R10 level committed", vol_level, 8'hC3);
    cmd(8'h02); cmd(8'h15); cmd(8'h29); cmd(8'h3F);
    chk("R8 windows", {win_a_first, win_a_len, win_b_first, win_b_len}, 16'h259F);
    cmd(8'h41); chk("R11 undefined 0x41 ignored", partial_en, 0);
    cmd(8'h40); chk("R8 partial enabled", partial_en, 1);
    cmd(8'h71); chk("R7 leave sub mode", sub_mode, 0);
    cmd(8'h8F); chk("R11 contrast byte ignored in main", vol_level, 8'hC3);
    cmd(8'h54); chk("R4 main start line again", start_line, 8'h43);
  endtask

  task automatic t_busy;
    @(negedge clk); rs = 1'b0; din = 8'hB1; wr_n = 1'b0;
    repeat (2) @(negedge clk); wr_n = 1'b1;
    @(negedge clk); rd_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R13 busy right after command", dout[7], 1);
    repeat (5) @(negedge clk);
    chk("R13 busy expired", dout[7], 0);
    rd_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_display_flags();
    t_addresses();
    t_data_path();
    t_clash();
    t_sub_table();
    t_busy();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule